// File: doc/BRIEF.md
# Four-Port Mailbox Interrupt Controller

This block produces the mailbox interrupts of a four-port memory in which every port runs on its own clock. Each port owns one mailbox address. A write to that address by any port raises the owner's interrupt. A read of the address by any port drops it again. The block looks only at each port's address and its read and write strobes. The data words, the memory array and access arbitration live elsewhere.

The event of the port doing the access is captured in that port's own clock domain as a toggle of a one-bit register. There is a set toggle and a clear toggle for each mailbox. The owner's domain brings every toggle in through a two-flop synchronizer and turns each change into a one-cycle pulse. A two-state flag machine, `FLAG_CLEAR` and `FLAG_SET`, then decides the flag. Its transitions are:
- set: `FLAG_CLEAR` to `FLAG_SET`, on any set pulse.
- clear: `FLAG_SET` to `FLAG_CLEAR`, on a clear pulse with no set pulse in the same cycle.
- hold: every other case.

The active-low interrupt is registered from the flag state on the owner's clock.

Top module: `mbx_irq_top`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first mailbox write, every `int_n` bit is 1. This holds for a reset at power-up and for a reset in the middle of operation.
- R2: The address decodes to interrupts as follows: FFFFh drives `int_n[0]`, FFFEh drives `int_n[1]`, FFFDh drives `int_n[2]` and FFFCh drives `int_n[3]`.
- R3: A write strobe from any port to a mailbox address drives that mailbox's `int_n` bit to 0. The bit changes only after synchronization into the owner's clock domain. No other bit changes.
- R4: A read strobe from any port to a mailbox address returns that mailbox's `int_n` bit to 1.
- R5: The flag is a level, not a count. Several writes to a mailbox, from one port or from several, are undone by a single read.
- R6: A read or a write to any address below FFFCh leaves every `int_n` bit unchanged.
- R7: A set and a clear may reach a flag in the same owner cycle, for example a port asserting read and write together on a mailbox. In that case the flag ends set.
- R8: Each `int_n` bit is a register in its owner's clock domain. On every owner clock edge it takes the inverse of the flag state from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | NPORTS | One clock per port; bit p clocks port p |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| addr | input | NPORTS*ADDR_W | Port p address in bits [p*ADDR_W +: ADDR_W] |
| wr_en | input | NPORTS | Write strobe per port, sampled on that port's clock |
| rd_en | input | NPORTS | Read strobe per port, sampled on that port's clock |
| int_n | output | NPORTS | Active-low mailbox interrupt, bit p on clock p |

## Verification
The bench sweeps every writer-reader pairing over all four mailboxes. A wrong crossbar column or a swapped address decode therefore shows up as the wrong bit moving. Repeated writes followed by one read separate a level flag from a counter. Writes and reads to neighbouring non-mailbox addresses catch a decode that is too wide. A port that strobes read and write together on one mailbox shows whether set or clear takes priority. A reset in the middle of a run, with flags set, shows that every domain clears.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DEF_NPORTS = 4;
    localparam int DEF_ADDR_W = 16;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= tgl_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign pulse = sync_q ^ last_q;
endmodule

// File: rtl/mbx_port.sv
module mbx_port #(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [NPORTS-1:0] set_tgl,
    output logic [NPORTS-1:0] clr_tgl
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    logic [NPORTS-1:0] hit;
    logic [NPORTS-1:0] set_tgl_q, clr_tgl_q;

    for (genvar m = 0; m < NPORTS; m++) begin : g_dec
        assign hit[m] = (addr == (TOP_ADDR - ADDR_W'(m)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_tgl_q <= '0;
            clr_tgl_q <= '0;
        end else begin
            if (wr_en) set_tgl_q <= set_tgl_q ^ hit;
            if (rd_en) clr_tgl_q <= clr_tgl_q ^ hit;
        end
    end

    assign set_tgl = set_tgl_q;
    assign clr_tgl = clr_tgl_q;

    // R6: an access outside the mailbox window sends no event
    a_r6_no_stray_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|hit)) |=> ($stable(set_tgl_q) && $stable(clr_tgl_q)));
endmodule

// File: rtl/mbx_owner.sv
module mbx_owner
    import mbx_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] set_tgl_in,
    input  logic [NPORTS-1:0] clr_tgl_in,
    output logic              int_n
);
    logic [NPORTS-1:0] set_p, clr_p;
    logic set_evt, clr_evt;
    flag_state_e state_q, state_d;
    logic int_n_q;

    for (genvar p = 0; p < NPORTS; p++) begin : g_sync
        mbx_sync u_set (.clk(clk), .rst_n(rst_n), .tgl_in(set_tgl_in[p]), .pulse(set_p[p]));
        mbx_sync u_clr (.clk(clk), .rst_n(rst_n), .tgl_in(clr_tgl_in[p]), .pulse(clr_p[p]));
    end

    assign set_evt = |set_p;
    assign clr_evt = |clr_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (set_evt)             state_d = FLAG_SET;
            FLAG_SET:   if (clr_evt && !set_evt) state_d = FLAG_CLEAR;
            default:                             state_d = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_n_q <= 1'b1;
        else        int_n_q <= (state_q != FLAG_SET);
    end

    assign int_n = int_n_q;

    // R7: set has priority over a coincident clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> (state_q == FLAG_SET));
    // R4: a lone clear empties the flag
    a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> (state_q == FLAG_CLEAR));
    // R5: no event, no change
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_evt && !clr_evt) |=> $stable(state_q));
    // R8: output register follows previous flag state
    a_r8_int_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int_n == ($past(state_q) != FLAG_SET)));
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
    import mbx_pkg::*;
#(
    parameter int NPORTS = DEF_NPORTS,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic [NPORTS-1:0]        clk,
    input  logic                     rst_n,
    input  logic [NPORTS*ADDR_W-1:0] addr,
    input  logic [NPORTS-1:0]        wr_en,
    input  logic [NPORTS-1:0]        rd_en,
    output logic [NPORTS-1:0]        int_n
);
    logic [NPORTS-1:0] set_row [NPORTS];
    logic [NPORTS-1:0] clr_row [NPORTS];
    logic [NPORTS-1:0] set_col [NPORTS];
    logic [NPORTS-1:0] clr_col [NPORTS];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        mbx_port #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_port (
            .clk    (clk[p]),
            .rst_n  (rst_n),
            .addr   (addr[p*ADDR_W +: ADDR_W]),
            .wr_en  (wr_en[p]),
            .rd_en  (rd_en[p]),
            .set_tgl(set_row[p]),
            .clr_tgl(clr_row[p])
        );
    end

    for (genvar m = 0; m < NPORTS; m++) begin : g_mbx
        for (genvar p = 0; p < NPORTS; p++) begin : g_xbar
            assign set_col[m][p] = set_row[p][m];
            assign clr_col[m][p] = clr_row[p][m];
        end
        mbx_owner #(.NPORTS(NPORTS)) u_owner (
            .clk       (clk[m]),
            .rst_n     (rst_n),
            .set_tgl_in(set_col[m]),
            .clr_tgl_in(clr_col[m]),
            .int_n     (int_n[m])
        );
    end
endmodule

// File: tb/mbx_irq_top_tb.sv
module mbx_irq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int AW = 16;

    logic [NP-1:0]    clk = '0;
    logic             rst_n = 1'b0;
    logic [NP*AW-1:0] addr = '0;
    logic [NP-1:0]    wr_en = '0;
    logic [NP-1:0]    rd_en = '0;
    logic [NP-1:0]    int_n;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;
    bit  exp_flag [NP];

    mbx_irq_top #(.NPORTS(NP), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .int_n(int_n)
    );

    // half periods 5, 6, 7, 8
    for (genvar p = 0; p < NP; p++) begin : g_clk
        always #(CLK_PERIOD / 2 + p) clk[p] = ~clk[p];
    end

    task automatic wait_neg(input int p);
        case (p)
            0: @(negedge clk[0]);
            1: @(negedge clk[1]);
            2: @(negedge clk[2]);
            default: @(negedge clk[3]);
        endcase
    endtask

    // reference model update: behavioural, set beats clear
    task automatic model(input logic [AW-1:0] a, input bit w, input bit r);
        if (a >= 16'hFFFC) begin
            int m = 16'hFFFF - a;
            if (w)      exp_flag[m] = 1'b1;
            else if (r) exp_flag[m] = 1'b0;
        end
    endtask

    task automatic do_op(input int p, input logic [AW-1:0] a, input bit w, input bit r);
        wait_neg(p);
        addr[p*AW +: AW] = a;
        wr_en[p] = w;
        rd_en[p] = r;
        wait_neg(p);
        wr_en[p] = 1'b0;
        rd_en[p] = 1'b0;
        model(a, w, r);
    endtask

    task automatic settle_check(input string req);
        repeat (12) @(negedge clk[3]);
        for (int m = 0; m < NP; m++) begin
            checks++;
            if (int_n[m] !== ~exp_flag[m]) begin
                errors++;
                $display("FAIL %s int_n[%0d] actual=%b expected=%b", req, m, int_n[m], ~exp_flag[m]);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk[3]);
        rst_n = 1'b0;
        for (int m = 0; m < NP; m++) exp_flag[m] = 1'b0;
        checks++;
        #1;
        if (int_n !== '1) begin
            errors++;
            $display("FAIL R1 int_n during reset actual=%b expected=1111", int_n);
        end
        repeat (3) @(negedge clk[3]);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int m = 0; m < NP; m++) exp_flag[m] = 1'b0;
        repeat (2) @(negedge clk[3]);
        rst_n = 1'b1;
        settle_check("R1");

        // R2/R3: one writer per mailbox, decode order
        do_op(0, 16'hFFFE, 1, 0); settle_check("R2 R3");
        do_op(3, 16'hFFFE, 0, 1); settle_check("R4");
        do_op(1, 16'hFFFF, 1, 0); settle_check("R2");
        do_op(2, 16'hFFFF, 0, 1); settle_check("R4");

        // R3/R4: every writer-reader pairing on every mailbox
        for (int w = 0; w < NP; w++) begin
            for (int m = 0; m < NP; m++) begin
                do_op(w, 16'hFFFF - 16'(m), 1, 0);
                settle_check("R3");
                do_op((w + m + 1) % NP, 16'hFFFF - 16'(m), 0, 1);
                settle_check("R4");
            end
        end

        // R5: repeated writes, single read
        do_op(0, 16'hFFFD, 1, 0);
        do_op(1, 16'hFFFD, 1, 0);
        do_op(3, 16'hFFFD, 1, 0);
        settle_check("R5");
        do_op(2, 16'hFFFD, 0, 1); settle_check("R5");

        // R6: neighbours of the mailbox window, with one flag held set
        do_op(1, 16'hFFFC, 1, 0); settle_check("R3");
        do_op(0, 16'hFFFB, 1, 0); settle_check("R6");
        do_op(2, 16'hFFFB, 0, 1); settle_check("R6");
        do_op(3, 16'h0000, 1, 1); settle_check("R6");
        do_op(2, 16'h7FFC, 0, 1); settle_check("R6");
        do_op(0, 16'hFFFC, 0, 1); settle_check("R4");

        // R7: read and write together on one mailbox
        do_op(2, 16'hFFFF, 1, 1); settle_check("R7");
        do_op(1, 16'hFFFE, 1, 1); settle_check("R7");
        do_op(3, 16'hFFFF, 0, 1); settle_check("R4");

        // R1: mid-run reset with flags set
        do_op(0, 16'hFFFC, 1, 0);
        do_op(3, 16'hFFFD, 1, 0);
        settle_check("R3");
        do_reset();
        settle_check("R1");
        do_op(3, 16'hFFFC, 1, 0); settle_check("R3");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule